// File: doc/BRIEF.md
# Loop-Index and Operand-Address Sequencer

This block is the control slot of a two-slot wide-instruction datapath for multi-word arithmetic. Each step it takes one control operation from the current instruction tuple and updates the instruction pointer and two index registers. The control operations are clear, increment, increment-and-branch, branch-on-carry, jump and end. In the same cycle it forms up to four data-memory operand addresses for the arithmetic slot of that tuple.

Each operand address is a base field plus an index term picked by a two-bit selector. Increment-and-branch compares an index register with a loadable loop bound and always post-increments it. With two index registers, a doubly nested multi-word loop needs no extra bookkeeping instructions.

Every decision in a tuple uses the register state from before that tuple. The operand addresses are combinational from the current index registers. The pointer, index and halt updates land on the clock edge that ends the step.

Top module: `lac_top`

## Requirements
- R1: After reset the instruction pointer is 0, the halt flag is 0, and both index registers are 0. With selector 3 every operand address then equals its base.
- R2: Operand address k equals base k plus the selected index term, modulo 2^DADDR_W. The selector encodings are 0 for zero, 1 for index one, 2 for index two and 3 for the sum of both. The index values are zero-extended.
- R3: The control op encoding is 0 none, 1 clear, 2 increment, 3 increment-and-branch, 4 branch-on-carry, 5 jump and 6 end; 7 acts as none. Register select 0 names index one and 1 names index two. Clear sets the named register to 0. Increment adds 1 to it, modulo 2^IX_W.
- R4: Increment-and-branch loads the target into the pointer when the named register differs from the loop bound. It increments the named register whether or not the branch is taken.
- R5: Branch-on-carry loads the target only when the carry input is 1. Jump always loads the target.
- R6: When no branch is taken, the pointer advances by 1, modulo 2^PC_W.
- R7: End raises the halt flag on the next edge and leaves the pointer unchanged. While halted, steps change neither the pointer nor the index registers until reset.
- R8: With step enable low, the pointer and index registers keep their values.
- R9: Within one step, the operand addresses and the branch decisions use the index registers, bound and carry as they were before the step.
- R10: A bound write loads the loop bound on the clock edge, whether or not a step is taken. An increment-and-branch in the same step compares against the old bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Execute the presented tuple on this edge |
| ctl_op | input | 3 | Control operation code |
| ctl_rsel | input | 1 | Index register named by the control op |
| ctl_target | input | PC_W | Branch and jump target |
| alu_carry | input | 1 | Carry flag from the arithmetic slot |
| bound_we | input | 1 | Load the loop bound |
| bound_val | input | IX_W | New loop bound value |
| opnd_base | input | N_OPND*DADDR_W | Packed operand base fields, operand 0 in the low bits |
| opnd_isel | input | N_OPND*2 | Packed index selectors |
| fetch_pc | output | PC_W | Address of the tuple to fetch |
| opnd_addr | output | N_OPND*DADDR_W | Packed effective operand addresses |
| halted | output | 1 | Program has ended |

## Verification
Some rules are checked on every cycle by assertions next to the logic:
- the zero-selector address rule;
- clear and increment-and-branch results on index one;
- jump and fall-through pointer updates;
- the stall when step enable is low;
- the freeze once halted.

Other behaviour needs the bench's reference model and scenarios:
- the branch-versus-bound decisions across a whole loop;
- the rule that each tuple uses the state from before it, including a bound write in the same tuple;
- index and pointer wrap-around;
- address wrap with mixed selectors;
- recovery from halt through reset.

// File: rtl/lac_pkg.sv
package lac_pkg;
   typedef enum logic [2:0] {
      CO_NOP   = 3'd0,
      CO_CLR   = 3'd1,
      CO_INC   = 3'd2,
      CO_INCBR = 3'd3,
      CO_BCS   = 3'd4,
      CO_JMP   = 3'd5,
      CO_END   = 3'd6,
      CO_RSV   = 3'd7
   } ctl_op_e;

   localparam logic [1:0] ISEL_ZERO = 2'd0;
   localparam logic [1:0] ISEL_IX1  = 2'd1;
   localparam logic [1:0] ISEL_IX2  = 2'd2;
   localparam logic [1:0] ISEL_BOTH = 2'd3;
endpackage

// File: rtl/lac_ixbank.sv
module lac_ixbank
   import lac_pkg::*;
#(
   parameter int IX_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            exec,
   input  ctl_op_e         op,
   input  logic            reg_sel,
   input  logic            bound_we,
   input  logic [IX_W-1:0] bound_val,
   output logic [IX_W-1:0] ix1,
   output logic [IX_W-1:0] ix2,
   output logic            loop_more
);
   localparam int N_IX = 2;

   if (IX_W < 1) begin : g_bad_w
      $error("lac_ixbank: IX_W must be at least 1");
   end

   logic [IX_W-1:0] bound_q;
   logic [IX_W-1:0] named;

   for (genvar g = 0; g < N_IX; g++) begin : g_ix
      logic [IX_W-1:0] q;
      logic            hit;
      assign hit = (reg_sel == 1'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (exec && hit) begin
            case (op)
               CO_CLR:           q <= '0;
               CO_INC, CO_INCBR: q <= q + 1'b1;
               default:          q <= q;
            endcase
         end
      end
   end

   assign ix1 = g_ix[0].q;
   assign ix2 = g_ix[1].q;

   always_ff @(posedge clk) begin
      if (!rst_n)        bound_q <= '0;
      else if (bound_we) bound_q <= bound_val;
   end

   assign named     = reg_sel ? ix2 : ix1;
   assign loop_more = (named != bound_q);

   // R3
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && op == CO_CLR && !reg_sel) |=> (ix1 == '0));

   // R4
   incbr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && op == CO_INCBR && !reg_sel) |=> (ix1 == IX_W'($past(ix1) + 1'b1)));

   // R8
   idle_ix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec) |=> ($stable(ix1) && $stable(ix2)));
endmodule

// File: rtl/lac_pcseq.sv
module lac_pcseq
   import lac_pkg::*;
#(
   parameter int PC_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_en,
   input  ctl_op_e         op,
   input  logic [PC_W-1:0] target,
   input  logic            alu_carry,
   input  logic            loop_more,
   output logic [PC_W-1:0] pc,
   output logic            halted,
   output logic            exec
);
   if (PC_W < 2) begin : g_bad_w
      $error("lac_pcseq: PC_W must be at least 2");
   end

   logic            take;
   logic [PC_W-1:0] pc_nxt;

   assign exec = step_en && !halted;

   always_comb begin
      case (op)
         CO_JMP:   take = 1'b1;
         CO_BCS:   take = alu_carry;
         CO_INCBR: take = loop_more;
         default:  take = 1'b0;
      endcase
   end

   always_comb begin
      if (op == CO_END) pc_nxt = pc;
      else if (take)    pc_nxt = target;
      else              pc_nxt = pc + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc     <= '0;
         halted <= 1'b0;
      end else if (exec) begin
         pc <= pc_nxt;
         if (op == CO_END) halted <= 1'b1;
      end
   end

   // R7
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(pc)));

   // R6
   fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && op == CO_NOP) |=> (pc == PC_W'($past(pc) + 1'b1)));

   // R5
   jmp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && op == CO_JMP) |=> (pc == $past(target)));

   // R8
   idle_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en) |=> $stable(pc));
endmodule

// File: rtl/lac_opnd_agen.sv
module lac_opnd_agen
   import lac_pkg::*;
#(
   parameter int N_OPND  = 4,
   parameter int DADDR_W = 8,
   parameter int IX_W    = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_OPND*DADDR_W-1:0]   base,
   input  logic [N_OPND*2-1:0]         isel,
   input  logic [IX_W-1:0]             ix1,
   input  logic [IX_W-1:0]             ix2,
   output logic [N_OPND*DADDR_W-1:0]   addr
);
   if (IX_W > DADDR_W) begin : g_bad_w
      $error("lac_opnd_agen: IX_W must not exceed DADDR_W");
   end
   if (N_OPND < 1) begin : g_bad_n
      $error("lac_opnd_agen: N_OPND must be at least 1");
   end

   logic [DADDR_W-1:0] ix1_x;
   logic [DADDR_W-1:0] ix2_x;
   logic [DADDR_W-1:0] pair_x;

   assign ix1_x  = DADDR_W'(ix1);
   assign ix2_x  = DADDR_W'(ix2);
   assign pair_x = ix1_x + ix2_x;

   for (genvar k = 0; k < N_OPND; k++) begin : g_op
      logic [DADDR_W-1:0] b;
      logic [1:0]         s;
      logic [DADDR_W-1:0] offs;
      assign b = base[k*DADDR_W +: DADDR_W];
      assign s = isel[k*2 +: 2];
      always_comb begin
         case (s)
            ISEL_IX1:  offs = ix1_x;
            ISEL_IX2:  offs = ix2_x;
            ISEL_BOTH: offs = pair_x;
            default:   offs = '0;
         endcase
      end
      assign addr[k*DADDR_W +: DADDR_W] = b + offs;

      // R2
      abs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (s == ISEL_ZERO) |-> (addr[k*DADDR_W +: DADDR_W] == b));
   end
endmodule

// File: rtl/lac_top.sv
module lac_top
   import lac_pkg::*;
#(
   parameter int PC_W    = 8,
   parameter int DADDR_W = 8,
   parameter int IX_W    = 6,
   parameter int N_OPND  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      step_en,
   input  logic [2:0]                ctl_op,
   input  logic                      ctl_rsel,
   input  logic [PC_W-1:0]           ctl_target,
   input  logic                      alu_carry,
   input  logic                      bound_we,
   input  logic [IX_W-1:0]           bound_val,
   input  logic [N_OPND*DADDR_W-1:0] opnd_base,
   input  logic [N_OPND*2-1:0]       opnd_isel,
   output logic [PC_W-1:0]           fetch_pc,
   output logic [N_OPND*DADDR_W-1:0] opnd_addr,
   output logic                      halted
);
   ctl_op_e         op;
   logic            exec;
   logic            loop_more;
   logic [IX_W-1:0] ix1;
   logic [IX_W-1:0] ix2;

   assign op = ctl_op_e'(ctl_op);

   lac_ixbank #(.IX_W(IX_W)) u_ix (
      .clk       (clk),
      .rst_n     (rst_n),
      .exec      (exec),
      .op        (op),
      .reg_sel   (ctl_rsel),
      .bound_we  (bound_we),
      .bound_val (bound_val),
      .ix1       (ix1),
      .ix2       (ix2),
      .loop_more (loop_more)
   );

   lac_pcseq #(.PC_W(PC_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_en   (step_en),
      .op        (op),
      .target    (ctl_target),
      .alu_carry (alu_carry),
      .loop_more (loop_more),
      .pc        (fetch_pc),
      .halted    (halted),
      .exec      (exec)
   );

   lac_opnd_agen #(.N_OPND(N_OPND), .DADDR_W(DADDR_W), .IX_W(IX_W)) u_agen (
      .clk   (clk),
      .rst_n (rst_n),
      .base  (opnd_base),
      .isel  (opnd_isel),
      .ix1   (ix1),
      .ix2   (ix2),
      .addr  (opnd_addr)
   );

   // R7
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> ($stable(ix1) && $stable(ix2)));
endmodule

// File: tb/lac_top_tb.sv
module lac_top_tb;
   localparam int PC_W = 8, DADDR_W = 8, IX_W = 6, N_OPND = 4;
   localparam int PC_M = 1 << PC_W, AD_M = 1 << DADDR_W, IX_M = 1 << IX_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic step_en = 1'b0;
   logic [2:0] ctl_op = 3'd0;
   logic ctl_rsel = 1'b0;
   logic [PC_W-1:0] ctl_target = '0;
   logic alu_carry = 1'b0;
   logic bound_we = 1'b0;
   logic [IX_W-1:0] bound_val = '0;
   logic [N_OPND*DADDR_W-1:0] opnd_base = '0;
   logic [N_OPND*2-1:0] opnd_isel = '0;
   logic [PC_W-1:0] fetch_pc;
   logic [N_OPND*DADDR_W-1:0] opnd_addr;
   logic halted;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   int m_pc, m_ix1, m_ix2, m_bnd, m_halt;
   int bases[N_OPND];
   int sels[N_OPND];

   always #4 clk = ~clk;

   lac_top #(.PC_W(PC_W), .DADDR_W(DADDR_W), .IX_W(IX_W), .N_OPND(N_OPND)) u_dut (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .ctl_op(ctl_op),
      .ctl_rsel(ctl_rsel), .ctl_target(ctl_target), .alu_carry(alu_carry),
      .bound_we(bound_we), .bound_val(bound_val), .opnd_base(opnd_base),
      .opnd_isel(opnd_isel), .fetch_pc(fetch_pc), .opnd_addr(opnd_addr),
      .halted(halted));

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic set_opnd(input int b0, b1, b2, b3, input int s0, s1, s2, s3);
      bases[0] = b0; bases[1] = b1; bases[2] = b2; bases[3] = b3;
      sels[0] = s0; sels[1] = s1; sels[2] = s2; sels[3] = s3;
   endtask

   // drive at negedge, compare just after, model advances at posedge
   task automatic run(input string tag, input int op, input int rsel, input int tgt,
                      input int carry, input bit step, input bit bwe, input int bval);
      int named, more, take;
      @(negedge clk);
      ctl_op = 3'(op); ctl_rsel = rsel[0]; ctl_target = PC_W'(tgt);
      alu_carry = carry[0]; step_en = step; bound_we = bwe; bound_val = IX_W'(bval);
      for (int k = 0; k < N_OPND; k++) begin
         opnd_base[k*DADDR_W +: DADDR_W] = DADDR_W'(bases[k]);
         opnd_isel[k*2 +: 2] = 2'(sels[k]);
      end
      #1;
      chk(tag, "pc", int'(fetch_pc), m_pc);
      chk(tag, "halted", int'(halted), m_halt);
      for (int k = 0; k < N_OPND; k++) begin
         int off;
         off = (sels[k] == 1) ? m_ix1 : (sels[k] == 2) ? m_ix2 :
               (sels[k] == 3) ? m_ix1 + m_ix2 : 0;
         chk(tag, $sformatf("addr%0d", k), int'(opnd_addr[k*DADDR_W +: DADDR_W]),
             (bases[k] + off) % AD_M);
      end
      @(posedge clk);
      if (step && m_halt == 0) begin
         named = rsel ? m_ix2 : m_ix1;
         more = (named != m_bnd);
         take = (op == 5) || (op == 4 && carry == 1) || (op == 3 && more);
         if (op == 6) m_halt = 1;
         else m_pc = take ? tgt : (m_pc + 1) % PC_M;
         if (op == 1) named = 0;
         else if (op == 2 || op == 3) named = (named + 1) % IX_M;
         if (rsel) m_ix2 = named; else m_ix1 = named;
      end
      if (bwe) m_bnd = bval;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; step_en = 1'b0; bound_we = 1'b0;
      repeat (2) @(posedge clk);
      m_pc = 0; m_ix1 = 0; m_ix2 = 0; m_bnd = 0; m_halt = 0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      set_opnd(10, 20, 30, 250, 3, 3, 3, 3);
      do_reset();
      // R1 reset state
      run("R1", 0, 0, 0, 0, 0, 0, 0);
      set_opnd(10, 20, 30, 250, 0, 1, 2, 3);
      // R10 bound load without a step
      run("R10", 0, 0, 0, 0, 0, 1, 3);
      // R3 clear and increments
      run("R3", 1, 0, 0, 0, 1, 0, 0);
      run("R3", 1, 1, 0, 0, 1, 0, 0);
      run("R3", 2, 1, 0, 0, 1, 0, 0);
      run("R3", 2, 1, 0, 0, 1, 0, 0);
      // R4 loop on index one with bound 3
      for (int i = 0; i < 6; i++) run("R4", 3, 0, 5, 0, 1, 0, 0);
      // R4 loop on index two
      for (int i = 0; i < 3; i++) run("R4", 3, 1, 9, 0, 1, 0, 0);
      // R9 increment and its own operands in one tuple
      run("R9", 2, 0, 0, 0, 1, 0, 0);
      run("R9", 2, 0, 0, 0, 1, 0, 0);
      // R5 branch on carry and jump
      run("R5", 4, 0, 40, 0, 1, 0, 0);
      run("R5", 4, 0, 40, 1, 1, 0, 0);
      run("R5", 5, 0, 255, 0, 1, 0, 0);
      // R6 fall-through wraps
      run("R6", 0, 0, 0, 0, 1, 0, 0);
      run("R6", 7, 0, 77, 1, 1, 0, 0);
      // R8 stalled steps
      for (int i = 0; i < 3; i++) run("R8", 5, 0, 99, 1, 0, 0, 0);
      // R10 and R9 bound write inside an increment-and-branch tuple
      run("R10", 1, 0, 0, 0, 1, 0, 0);
      run("R10", 3, 0, 20, 0, 1, 1, 0);
      run("R10", 3, 0, 30, 0, 1, 0, 0);
      run("R10", 3, 0, 30, 0, 1, 0, 0);
      // R3 index wrap
      for (int i = 0; i < IX_M + 3; i++) run("R3", 2, 0, 0, 0, 1, 0, 0);
      // R2 mixed selectors and address wrap
      set_opnd(255, 128, 0, 200, 3, 3, 1, 2);
      for (int i = 0; i < 4; i++) run("R2", 2, 1, 0, 0, 1, 0, 0);
      set_opnd(250, 7, 254, 60, 1, 0, 3, 2);
      run("R2", 2, 0, 0, 0, 1, 0, 0);
      run("R2", 0, 0, 0, 0, 1, 0, 0);
      // R7 end and frozen state
      run("R7", 6, 0, 0, 0, 1, 0, 0);
      run("R7", 5, 0, 3, 1, 1, 0, 0);
      run("R7", 2, 0, 0, 0, 1, 0, 0);
      run("R7", 1, 1, 0, 0, 1, 0, 0);
      run("R7", 3, 1, 1, 0, 1, 0, 0);
      // R1 reset clears the halt
      set_opnd(10, 20, 30, 250, 3, 3, 3, 3);
      do_reset();
      run("R1", 0, 0, 0, 0, 0, 0, 0);
      run("R6", 0, 0, 0, 0, 1, 0, 0);
      run("R6", 0, 0, 0, 0, 1, 0, 0);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule